// File: doc/BRIEF.md
# Vectored Interrupt Controller with Memory-Mapped Registers

This block gathers 32 interrupt request lines for a host processor and presents them through eight 32-bit registers in a 32-byte window. Each request line owns one bit position in every register. Requests are latched into a status register and qualified by an enable register. The qualified set is the pending register. A priority encoder reports the lowest-numbered pending line through a vector register. Software uses that number directly as the interrupt number.

Software does not have to read, modify and write the enable register. Separate set-enable and clear-enable aliases let it change single enable bits in one write. A write-one-to-acknowledge register drops latched requests. A two-bit control register gates the whole controller and the output wire to the processor.

Whether a line is level or edge sensitive is fixed when the design is built, through a per-line parameter mask. Every line is level sensitive by default. A level line whose input is still high after an acknowledge latches again on the next clock.

Top module: `irq_vector_ctrl`

## Requirements
- R1: The register is selected by byte address bits [4:2]: 0 status, 4 pending, 8 enable (read/write), 12 acknowledge, 16 set-enable, 20 clear-enable, 24 vector, 28 control.
- R2: A level-sensitive line sets its status bit at every clock edge where its input is high. The bit stays set after the input falls, until it is acknowledged.
- R3: An edge-sensitive line (EDGE_LINES bit = 1) sets its status bit only at a clock edge where its input is high and was low at the previous edge. Holding the input high sets the bit no more than once.
- R4: Writing to address 12 clears the status bits where the data has ones, and an acknowledge wins over a new request in the same cycle. A level line still held high reads as set again one cycle later.
- R5: Writing to address 16 sets the enable bits where the data has ones and leaves all other enable bits unchanged.
- R6: Writing to address 20 clears the enable bits where the data has ones and leaves all other enable bits unchanged.
- R7: The pending register reads as status AND enable.
- R8: The vector register reads as the index of the lowest-numbered pending bit, zero-extended. It reads as 0xFFFFFFFF when nothing is pending.
- R9: irq_out is high only when control bit 0 (controller on) and control bit 1 (output on) are both 1 and at least one pending bit is set.
- R10: Reset clears status, enable and control. The addresses 12, 16 and 20 always read as zero, and rdata is zero whenever rd_en is low.
- R11: Writes to the status, pending and vector addresses have no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all state changes on its rising edge |
| rst | input | 1 | Synchronous active-high reset |
| addr | input | 5 | Byte address inside the 32-byte register window |
| wr_en | input | 1 | Write strobe, one write per cycle it is high |
| wdata | input | 32 | Write data |
| rd_en | input | 1 | Read strobe; rdata is combinational from addr while high |
| rdata | output | 32 | Read data, zero when rd_en is low |
| irq_in | input | 32 | Interrupt request lines, bit i is line i |
| irq_out | output | 1 | Interrupt request to the processor |

## Verification
The bench acknowledges all lines while a level line is still high. It expects the status bit to be clear right after the write and set again one cycle later. A design that let the new request beat the acknowledge would never show the cleared state. A design that dropped level re-latching would lose the interrupt.

An edge-configured line is held high across an acknowledge and must stay clear, because a design that treated it as level would latch it again. The enable aliases are checked for bits they must leave alone. This catches an alias implemented as a plain store.

Line 0 against line 31, and an empty pending set, probe both ends of the priority encoder and its all-ones idle value. Setting only one of the two control bits must keep irq_out low.

// File: rtl/vic_pkg.sv
package vic_pkg;

    localparam int NUM_LINES = 32;
    localparam int DATA_W    = 32;
    localparam int ADDR_W    = 5;
    localparam int IDX_W     = $clog2(NUM_LINES);
    localparam int SEL_W     = 3;

    // Register selector, taken from byte address bits [4:2]
    typedef enum logic [SEL_W-1:0] {
        SEL_STATUS = 3'd0,
        SEL_PEND   = 3'd1,
        SEL_ENABLE = 3'd2,
        SEL_ACK    = 3'd3,
        SEL_ENSET  = 3'd4,
        SEL_ENCLR  = 3'd5,
        SEL_VECTOR = 3'd6,
        SEL_CTRL   = 3'd7
    } reg_sel_e;

    // Control register: bit 1 gates the output wire, bit 0 gates the controller
    typedef struct packed {
        logic out_on;
        logic core_on;
    } ctrl_t;

    typedef struct packed {
        logic             valid;
        logic [IDX_W-1:0] idx;
    } vec_t;

    function automatic reg_sel_e decode_sel(input logic [ADDR_W-1:0] a);
        return reg_sel_e'(a[ADDR_W-1:2]);
    endfunction

endpackage

// File: rtl/vic_capture.sv
module vic_capture
    import vic_pkg::*;
#(
    parameter int                   N          = NUM_LINES,
    parameter logic [NUM_LINES-1:0] EDGE_LINES = '0
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] req_in,
    input  logic [N-1:0] ack_mask,
    output logic [N-1:0] status
);

    logic [N-1:0] hit;

    for (genvar i = 0; i < N; i++) begin : g_line
        if (EDGE_LINES[i]) begin : g_edge
            logic prev_q;
            always_ff @(posedge clk) begin
                if (rst) prev_q <= 1'b0;
                else     prev_q <= req_in[i];
            end
            assign hit[i] = req_in[i] & ~prev_q;
        end else begin : g_level
            assign hit[i] = req_in[i];
        end

        always_ff @(posedge clk) begin
            if (rst)              status[i] <= 1'b0;
            else if (ack_mask[i]) status[i] <= 1'b0;
            else if (hit[i])      status[i] <= 1'b1;
        end
    end

    // R4: acknowledged bits are clear in the cycle after the acknowledge
    a_r4_ack_clears: assert property (@(posedge clk) disable iff (rst)
        (ack_mask != '0) |=> ((status & $past(ack_mask)) == '0));

    // R2: a latched bit stays latched unless acknowledged
    a_r2_sticky: assert property (@(posedge clk) disable iff (rst)
        (ack_mask == '0) |=> ((status & $past(status)) == $past(status)));

endmodule

// File: rtl/vic_prio.sv
module vic_prio
    import vic_pkg::*;
#(
    parameter int N = NUM_LINES
) (
    input  logic [N-1:0] pend,
    output vec_t         vec
);

    always_comb begin
        vec = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (pend[i]) begin
                vec.valid = 1'b1;
                vec.idx   = IDX_W'(i);
            end
        end
    end

    // R8: the chosen index is pending and no lower index is
    always_comb begin
        logic [N-1:0] below;
        below = '0;
        for (int i = 0; i < N; i++) below[i] = (IDX_W'(i) < vec.idx);
        if (vec.valid)
            a_r8_lowest: assert (pend[vec.idx] && ((pend & below) == '0));
        else
            a_r8_empty: assert (pend == '0);
    end

endmodule

// File: rtl/irq_vector_ctrl.sv
module irq_vector_ctrl
    import vic_pkg::*;
#(
    parameter logic [NUM_LINES-1:0] EDGE_LINES = '0
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] addr,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wdata,
    input  logic              rd_en,
    output logic [DATA_W-1:0] rdata,
    input  logic [NUM_LINES-1:0] irq_in,
    output logic              irq_out
);

    reg_sel_e             sel;
    logic                 unused_addr_lsbs;
    logic [NUM_LINES-1:0] status;
    logic [NUM_LINES-1:0] enable_q;
    logic [NUM_LINES-1:0] pend;
    logic [NUM_LINES-1:0] ack_mask;
    ctrl_t                ctrl_q;
    vec_t                 vec;

    assign sel              = decode_sel(addr);
    assign unused_addr_lsbs = ^addr[1:0];
    assign ack_mask         = (wr_en && sel == SEL_ACK) ? wdata[NUM_LINES-1:0] : '0;

    vic_capture #(.N(NUM_LINES), .EDGE_LINES(EDGE_LINES)) u_capture (
        .clk      (clk),
        .rst      (rst),
        .req_in   (irq_in),
        .ack_mask (ack_mask),
        .status   (status)
    );

    assign pend = status & enable_q;

    vic_prio #(.N(NUM_LINES)) u_prio (
        .pend (pend),
        .vec  (vec)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            enable_q <= '0;
            ctrl_q   <= '0;
        end else if (wr_en) begin
            unique case (sel)
                SEL_ENABLE: enable_q <= wdata[NUM_LINES-1:0];
                SEL_ENSET:  enable_q <= enable_q | wdata[NUM_LINES-1:0];
                SEL_ENCLR:  enable_q <= enable_q & ~wdata[NUM_LINES-1:0];
                SEL_CTRL:   ctrl_q   <= ctrl_t'(wdata[1:0]);
                default: ;
            endcase
        end
    end

    always_comb begin
        rdata = '0;
        if (rd_en) begin
            unique case (sel)
                SEL_STATUS: rdata = DATA_W'(status);
                SEL_PEND:   rdata = DATA_W'(pend);
                SEL_ENABLE: rdata = DATA_W'(enable_q);
                SEL_VECTOR: rdata = vec.valid ? DATA_W'(vec.idx) : '1;
                SEL_CTRL:   rdata = DATA_W'(ctrl_q);
                default:    rdata = '0;
            endcase
        end
    end

    assign irq_out = ctrl_q.core_on & ctrl_q.out_on & vec.valid;

    // R5: set-enable turns on the written bits and keeps the others
    a_r5_set_enable: assert property (@(posedge clk) disable iff (rst)
        (wr_en && sel == SEL_ENSET) |=>
            ((enable_q & $past(wdata)) == $past(wdata)) &&
            ((enable_q & ~$past(wdata)) == ($past(enable_q) & ~$past(wdata))));

    // R6: clear-enable turns off the written bits and keeps the others
    a_r6_clr_enable: assert property (@(posedge clk) disable iff (rst)
        (wr_en && sel == SEL_ENCLR) |=>
            ((enable_q & $past(wdata)) == '0) &&
            ((enable_q & ~$past(wdata)) == ($past(enable_q) & ~$past(wdata))));

    // R10: reset leaves enable and control cleared
    a_r10_reset: assert property (@(posedge clk)
        rst |=> (enable_q == '0 && ctrl_q == '0));

    // R9: the output never rises while the controller is gated off
    a_r9_gated: assert property (@(posedge clk) disable iff (rst)
        (ctrl_q != 2'b11) |-> !irq_out);

    // R11: no register changes on a write to a read-only address
    a_r11_read_only: assert property (@(posedge clk) disable iff (rst)
        (wr_en && (sel == SEL_STATUS || sel == SEL_PEND || sel == SEL_VECTOR)) |=>
            ($stable(enable_q) && $stable(ctrl_q)));

endmodule

// File: tb/irq_vector_ctrl_test.sv
module irq_vector_ctrl_test;

    localparam int CLK_PERIOD = 10;
    localparam logic [31:0] EDGE_SET = 32'hFFFF_0000;

    localparam logic [4:0] A_STAT = 5'd0,  A_PEND = 5'd4,  A_EN  = 5'd8,  A_ACK = 5'd12;
    localparam logic [4:0] A_SET  = 5'd16, A_CLR  = 5'd20, A_VEC = 5'd24, A_CTL = 5'd28;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [4:0]  addr = '0;
    logic        wr_en = 1'b0;
    logic [31:0] wdata = '0;
    logic        rd_en = 1'b0;
    logic [31:0] rdata;
    logic [31:0] irq_in = '0;
    logic        irq_out;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    irq_vector_ctrl #(.EDGE_LINES(EDGE_SET)) uut (
        .clk(clk), .rst(rst), .addr(addr), .wr_en(wr_en), .wdata(wdata),
        .rd_en(rd_en), .rdata(rdata), .irq_in(irq_in), .irq_out(irq_out)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: got %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [4:0] a, input logic [31:0] d);
        @(negedge clk);
        addr = a; wdata = d; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd_check(input string req, input logic [4:0] a, input logic [31:0] exp);
        addr = a; rd_en = 1'b1;
        #1;
        check(req, rdata, exp);
        rd_en = 1'b0;
    endtask

    task automatic tick(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic t_reset();
        rd_check("R10", A_STAT, 32'h0);
        rd_check("R10", A_EN,   32'h0);
        rd_check("R10", A_CTL,  32'h0);
        rd_check("R10", A_ACK,  32'h0);
        rd_check("R10", A_SET,  32'h0);
        rd_check("R10", A_CLR,  32'h0);
        rd_check("R8",  A_VEC,  32'hFFFF_FFFF);
        check("R9", {31'h0, irq_out}, 32'h0);
        addr = A_VEC; rd_en = 1'b0; #1;
        check("R10", rdata, 32'h0);
    endtask

    task automatic t_level_latch();
        @(negedge clk); irq_in[5] = 1'b1;
        @(negedge clk); irq_in[5] = 1'b0;
        tick(2);
        rd_check("R2", A_STAT, 32'h0000_0020);
        rd_check("R7", A_PEND, 32'h0);
    endtask

    task automatic t_enable_and_output();
        wr(A_SET, 32'h0000_0120);
        rd_check("R5", A_EN,   32'h0000_0120);
        rd_check("R7", A_PEND, 32'h0000_0020);
        rd_check("R8", A_VEC,  32'd5);
        check("R9", {31'h0, irq_out}, 32'h0);
        wr(A_CTL, 32'h1);
        check("R9", {31'h0, irq_out}, 32'h0);
        wr(A_CTL, 32'h2);
        check("R9", {31'h0, irq_out}, 32'h0);
        wr(A_CTL, 32'h3);
        check("R9", {31'h0, irq_out}, 32'h1);
        wr(A_SET, 32'h0000_0008);
        rd_check("R5", A_EN, 32'h0000_0128);
    endtask

    task automatic t_priority();
        @(negedge clk); irq_in[3] = 1'b1;
        @(negedge clk);
        rd_check("R8", A_VEC, 32'd3);
        wr(A_CLR, 32'h0000_0020);
        rd_check("R6", A_EN,   32'h0000_0108);
        rd_check("R7", A_PEND, 32'h0000_0008);
    endtask

    task automatic t_ack_level();
        wr(A_ACK, 32'hFFFF_FFFF);
        rd_check("R4", A_STAT, 32'h0);
        check("R9", {31'h0, irq_out}, 32'h0);
        @(negedge clk);
        rd_check("R4", A_STAT, 32'h0000_0008);
        irq_in[3] = 1'b0;
        wr(A_ACK, 32'h0000_0008);
        tick(1);
        rd_check("R4", A_STAT, 32'h0);
        rd_check("R8", A_VEC, 32'hFFFF_FFFF);
    endtask

    task automatic t_top_line();
        wr(A_EN, 32'h8000_0001);
        rd_check("R1", A_EN, 32'h8000_0001);
        @(negedge clk); irq_in[31] = 1'b1;
        @(negedge clk); irq_in[31] = 1'b0;
        rd_check("R8", A_VEC, 32'd31);
        @(negedge clk); irq_in[0] = 1'b1;
        @(negedge clk); irq_in[0] = 1'b0;
        rd_check("R8", A_VEC, 32'd0);
        wr(A_ACK, 32'h8000_0001);
        rd_check("R4", A_STAT, 32'h0);
    endtask

    task automatic t_edge_line();
        @(negedge clk); irq_in[20] = 1'b1;
        tick(3);
        rd_check("R3", A_STAT, 32'h0010_0000);
        wr(A_ACK, 32'h0010_0000);
        tick(3);
        rd_check("R3", A_STAT, 32'h0);
        irq_in[20] = 1'b0;
        tick(1);
        irq_in[20] = 1'b1;
        tick(1);
        rd_check("R3", A_STAT, 32'h0010_0000);
        irq_in[20] = 1'b0;
        wr(A_ACK, 32'h0010_0000);
    endtask

    task automatic t_read_only();
        wr(A_STAT, 32'hFFFF_FFFF);
        wr(A_PEND, 32'hFFFF_FFFF);
        wr(A_VEC,  32'h0000_0000);
        rd_check("R11", A_STAT, 32'h0);
        rd_check("R11", A_EN,   32'h8000_0001);
        rd_check("R11", A_CTL,  32'h3);
        rd_check("R11", A_VEC,  32'hFFFF_FFFF);
    endtask

    initial begin
        tick(3);
        rst = 1'b0;
        t_reset();
        t_level_latch();
        t_enable_and_output();
        t_priority();
        t_ack_level();
        t_top_line();
        t_edge_line();
        t_read_only();
        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                #(CLK_PERIOD * 20000);
                n_checks++;
                n_fail++;
                $display("FAIL watchdog: got timeout expected completion");
            end
        join_any
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule